// File: doc/BRIEF.md
# Seconds-Tick Time and Calendar Counter

This block holds the time of day and the calendar date as seven byte-wide fields: seconds, minutes, hours, day of week, date of month, month and a two-digit year. A single-cycle tick, produced elsewhere once per second, advances the fields. Carries pass from seconds up to the year, and the block corrects February for leap years. Two run-time controls choose how the fields are encoded. One picks plain binary or packed BCD. The other picks a 24-hour clock or a 12-hour clock with a PM flag.

Software loads the fields through a byte-wide write port. It holds the counter still while it does so, so that no carry can fall between two writes. An optional daylight-saving mode moves the clock forward one hour early on the first Sunday of April. It moves the clock back one hour, once only, on the last Sunday of October. After every advance the block raises a one-cycle completion pulse. A divider, an alarm comparator or an interrupt controller can use that pulse.

Top module: `caltime_core`

## Requirements
- R1: Each accepted tick adds one second. A seconds wrap from 59 to 0 adds one minute, a minutes wrap adds one hour, and a wrap past the last hour of the day advances the date. A wrap past the last date of the month advances the month, and a wrap from month 12 to month 1 advances the year, which goes from 99 back to 00.
- R2: Month lengths are 31 days, except months 4, 6, 9 and 11, which have 30. February has 29 days when the year field is divisible by four and 28 days otherwise. Year 00 counts as a leap year.
- R3: When `fmt_bin` = 1, each field holds its value as a plain binary number. When `fmt_bin` = 0, each field holds two BCD digits, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R4: When `hr24` = 1, the hour field counts from 0 to 23 and bit 7 carries no meaning.
- R5: When `hr24` = 0, the hour field keeps the hour in bits 6:0 and counts 12, 1, 2 and so on up to 11. Bit 7 is the PM flag (1 = PM). The flag changes on the step from 11:59:59 to 12:00:00. The step from 11:59:59 PM to 12:00:00 AM also advances the date.
- R6: While `hold` = 1, a tick changes no field and produces no completion pulse.
- R7: A write with `wr_en` = 1 loads `wr_data` into one field, chosen by `wr_sel`: 0 for seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. Codes 7 and above change nothing. If a write falls in the same cycle as a tick, the write takes effect and the tick is dropped.
- R8: Day of week runs from 1 (Sunday) to 7 and steps once at each midnight, from 7 back to 1.
- R9: With `dst_en` = 1, the step out of 01:59:59 AM goes straight to 03:00:00 AM when three conditions hold: the month is 4, the day of week is 1 and the date is 7 or less.
- R10: With `dst_en` = 1, the step out of 01:59:59 AM goes to 01:00:00 AM when three conditions hold: the month is 10, the day of week is 1 and the date is 25 or more. This happens only the first time the clock reaches that moment. The next pass through 01:59:59 on that day advances normally. A write or a midnight rollover clears this once-only memory.
- R11: With `dst_en` = 0, neither daylight-saving jump takes place.
- R12: `upd_done` is high for exactly one cycle, in the cycle after each accepted tick, and the new field values are visible in that same cycle.
- R13: Changing `fmt_bin` or `hr24` does not convert fields already stored. The stored bytes are read in the new format from then on.
- R14: Synchronous reset loads 00:00:00 on the 24-hour encoding, with day of week 1, date 1, month 1 and year 00, and clears `upd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle pulse, once per second |
| hold | input | 1 | 1 stops all advancing |
| fmt_bin | input | 1 | 1 = binary fields, 0 = BCD fields |
| hr24 | input | 1 | 1 = 24-hour clock, 0 = 12-hour with PM flag |
| dst_en | input | 1 | Enables the two daylight-saving jumps |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Byte to write |
| sec_o | output | 8 | Seconds field |
| min_o | output | 8 | Minutes field |
| hour_o | output | 8 | Hours field (bit 7 = PM in 12-hour form) |
| wday_o | output | 8 | Day of week field |
| date_o | output | 8 | Date of month field |
| month_o | output | 8 | Month field |
| year_o | output | 8 | Two-digit year field |
| upd_done | output | 1 | Completion pulse after an advance |

## Verification
A field write and a tick can arrive in the same cycle. The bench forces this by raising `wr_en` and `tick` on the same negative edge, with a new seconds value on the data port. It then expects the written value, all other fields unchanged and no completion pulse. The daylight-saving fall-back and the normal carry also meet on the same 01:59:59 state. The bench lets the clock run through a whole repeated hour and expects the second crossing to reach 02:00:00.

// File: rtl/caltime_pkg.sv
// Package: field layout, the internal binary time record, and the
// conversions between a stored byte and its binary value.
// Assumes: every field value fits in seven bits (at most 99).
package caltime_pkg;

    localparam int BYTE_W   = 8;
    localparam int VAL_W    = 7;
    localparam int N_FIELDS = 7;
    localparam int SEL_W    = $clog2(N_FIELDS + 1);

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_WDAY  = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6
    } field_e;

    // binary view of the time; hr always holds the 24-hour value
    typedef struct packed {
        logic [VAL_W-1:0] sec;
        logic [VAL_W-1:0] min;
        logic [VAL_W-1:0] hr;
        logic [VAL_W-1:0] wday;
        logic [VAL_W-1:0] date;
        logic [VAL_W-1:0] mon;
        logic [VAL_W-1:0] year;
    } tod_t;

    // stored byte to binary value, read as binary or as two BCD digits
    function automatic logic [VAL_W-1:0] unpack_val(input logic [BYTE_W-1:0] raw,
                                                    input logic bin);
        logic [VAL_W-1:0] tens;
        logic [VAL_W-1:0] ones;
        tens = {3'd0, raw[7:4]};
        ones = {3'd0, raw[3:0]};
        return bin ? raw[VAL_W-1:0] : (tens * 7'd10 + ones);
    endfunction

    // binary value to stored byte, as binary or as two BCD digits
    function automatic logic [BYTE_W-1:0] pack_val(input logic [VAL_W-1:0] v,
                                                  input logic bin);
        logic [VAL_W-1:0] tens;
        logic [VAL_W-1:0] ones;
        tens = v / 7'd10;
        ones = v - tens * 7'd10;
        return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
    endfunction

endpackage

// File: rtl/caltime_days.sv
// Month-length lookup: gives the number of days in the current month.
// Assumes: a leap year is any year whose value is a multiple of LEAP_STEP,
// and LEAP_STEP is a power of two.
module caltime_days
    import caltime_pkg::*;
#(
    parameter int LEAP_STEP = 4
) (
    input  logic [VAL_W-1:0] month,
    input  logic [VAL_W-1:0] year,
    output logic [4:0]       ndays
);
    localparam int LEAP_BITS = $clog2(LEAP_STEP);

    logic leap;

    // a year is a leap year when its low bits are all zero
    assign leap = (year[LEAP_BITS-1:0] == '0);

    // pick the month length
    always_comb begin
        unique case (month)
            7'd2:                        ndays = leap ? 5'd29 : 5'd28;
            7'd4, 7'd6, 7'd9, 7'd11:     ndays = 5'd30;
            default:                     ndays = 5'd31;
        endcase
    end
endmodule

// File: rtl/caltime_step.sv
// Next-second calculator: takes the current binary time and gives the
// time one second later. It applies the carry chain, the weekday wrap and
// the two daylight-saving jumps. Purely combinational.
// Assumes: the hour is in 24-hour form; fall_done records that the
// fall-back jump has already been taken on this day.
module caltime_step
    import caltime_pkg::*;
#(
    parameter int YEAR_SPAN    = 100,
    parameter int SPRING_MONTH = 4,
    parameter int FALL_MONTH   = 10,
    parameter int SHIFT_HOUR   = 1,
    parameter int WEEK_DAYS    = 7,
    parameter int FALL_MONTH_DAYS = 31
) (
    input  tod_t       cur,
    input  logic [4:0] ndays,
    input  logic       dst_en,
    input  logic       fall_done,
    output tod_t       nxt,
    output logic       fall_fire,
    output logic       day_wrap,
    output logic       year_wrap
);
    localparam logic [VAL_W-1:0] YEAR_LAST  = VAL_W'(YEAR_SPAN - 1);
    localparam logic [VAL_W-1:0] SPRING_MON = VAL_W'(SPRING_MONTH);
    localparam logic [VAL_W-1:0] FALL_MON   = VAL_W'(FALL_MONTH);
    localparam logic [VAL_W-1:0] JUMP_HR    = VAL_W'(SHIFT_HOUR);
    localparam logic [VAL_W-1:0] AFTER_HR   = VAL_W'(SHIFT_HOUR + 2);
    localparam logic [VAL_W-1:0] LAST_WDAY  = VAL_W'(WEEK_DAYS);
    localparam logic [VAL_W-1:0] WEEK1_END  = VAL_W'(WEEK_DAYS);
    localparam logic [VAL_W-1:0] LASTWK_BEG = VAL_W'(FALL_MONTH_DAYS - WEEK_DAYS + 1);

    logic at_shift;
    logic spring_fire;

    // last second of the hour in which both jumps happen, on a Sunday
    assign at_shift    = (cur.hr == JUMP_HR) && (cur.min == 7'd59) &&
                         (cur.sec == 7'd59) && (cur.wday == 7'd1);
    assign spring_fire = dst_en && at_shift && (cur.mon == SPRING_MON) &&
                         (cur.date <= WEEK1_END);
    assign fall_fire   = dst_en && at_shift && !fall_done &&
                         (cur.mon == FALL_MON) && (cur.date >= LASTWK_BEG);

    // carry chain with the daylight-saving overrides applied last
    always_comb begin
        nxt       = cur;
        day_wrap  = 1'b0;
        year_wrap = 1'b0;
        if (cur.sec < 7'd59) begin
            nxt.sec = cur.sec + 7'd1;
        end else begin
            nxt.sec = '0;
            if (cur.min < 7'd59) begin
                nxt.min = cur.min + 7'd1;
            end else begin
                nxt.min = '0;
                if (cur.hr < 7'd23) begin
                    nxt.hr = cur.hr + 7'd1;
                end else begin
                    nxt.hr   = '0;
                    day_wrap = 1'b1;
                    nxt.wday = (cur.wday >= LAST_WDAY) ? 7'd1 : cur.wday + 7'd1;
                    if (cur.date < {2'b00, ndays}) begin
                        nxt.date = cur.date + 7'd1;
                    end else begin
                        nxt.date = 7'd1;
                        if (cur.mon < 7'd12) begin
                            nxt.mon = cur.mon + 7'd1;
                        end else begin
                            nxt.mon   = 7'd1;
                            year_wrap = 1'b1;
                            nxt.year  = (cur.year >= YEAR_LAST) ? '0 : cur.year + 7'd1;
                        end
                    end
                end
            end
        end
        if (spring_fire) begin
            nxt.hr = AFTER_HR;
        end else if (fall_fire) begin
            nxt.hr = JUMP_HR;
        end
    end
endmodule

// File: rtl/caltime_core.sv
// Time and calendar counter top. It holds seven encoded byte fields,
// accepts software writes, and advances by one second on each tick that
// is not held or overridden by a write.
// Assumes: tick is a single-cycle pulse, and software loads fields that
// are valid in the encoding currently selected.
module caltime_core
    import caltime_pkg::*;
#(
    parameter int YEAR_SPAN    = 100,
    parameter int LEAP_STEP    = 4,
    parameter int SPRING_MONTH = 4,
    parameter int FALL_MONTH   = 10,
    parameter int SHIFT_HOUR   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hold,
    input  logic       fmt_bin,
    input  logic       hr24,
    input  logic       dst_en,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic       upd_done
);
    logic [BYTE_W-1:0] fld_q [N_FIELDS];
    logic [BYTE_W-1:0] fld_n [N_FIELDS];
    tod_t              cur;
    tod_t              nxt;
    logic [4:0]        ndays;
    logic              fall_fire;
    logic              day_wrap;
    logic              year_wrap;
    logic              fall_done;
    logic              adv;
    logic [VAL_W-1:0]  h12_in;
    logic [VAL_W-1:0]  h12_out;
    logic [BYTE_W-1:0] h12_byte;

    // a tick counts only when not held and not overridden by a write
    assign adv = tick && !hold && !wr_en;

    // read the stored bytes as binary values, with the hour in 24-hour form
    always_comb begin
        cur.sec  = unpack_val(fld_q[FLD_SEC], fmt_bin);
        cur.min  = unpack_val(fld_q[FLD_MIN], fmt_bin);
        cur.wday = unpack_val(fld_q[FLD_WDAY], fmt_bin);
        cur.date = unpack_val(fld_q[FLD_DATE], fmt_bin);
        cur.mon  = unpack_val(fld_q[FLD_MONTH], fmt_bin);
        cur.year = unpack_val(fld_q[FLD_YEAR], fmt_bin);
        h12_in   = unpack_val({1'b0, fld_q[FLD_HOUR][6:0]}, fmt_bin);
        if (hr24) begin
            cur.hr = unpack_val(fld_q[FLD_HOUR], fmt_bin);
        end else if (h12_in == 7'd12) begin
            cur.hr = fld_q[FLD_HOUR][7] ? 7'd12 : 7'd0;
        end else begin
            cur.hr = fld_q[FLD_HOUR][7] ? h12_in + 7'd12 : h12_in;
        end
    end

    caltime_days #(
        .LEAP_STEP (LEAP_STEP)
    ) u_days (
        .month (cur.mon),
        .year  (cur.year),
        .ndays (ndays)
    );

    caltime_step #(
        .YEAR_SPAN    (YEAR_SPAN),
        .SPRING_MONTH (SPRING_MONTH),
        .FALL_MONTH   (FALL_MONTH),
        .SHIFT_HOUR   (SHIFT_HOUR)
    ) u_step (
        .cur       (cur),
        .ndays     (ndays),
        .dst_en    (dst_en),
        .fall_done (fall_done),
        .nxt       (nxt),
        .fall_fire (fall_fire),
        .day_wrap  (day_wrap),
        .year_wrap (year_wrap)
    );

    // turn the next binary time back into stored bytes
    always_comb begin
        fld_n[FLD_SEC]   = pack_val(nxt.sec, fmt_bin);
        fld_n[FLD_MIN]   = pack_val(nxt.min, fmt_bin);
        fld_n[FLD_WDAY]  = pack_val(nxt.wday, fmt_bin);
        fld_n[FLD_DATE]  = pack_val(nxt.date, fmt_bin);
        fld_n[FLD_MONTH] = pack_val(nxt.mon, fmt_bin);
        fld_n[FLD_YEAR]  = pack_val(nxt.year, fmt_bin);
        h12_out = (nxt.hr >= 7'd12) ? nxt.hr - 7'd12 : nxt.hr;
        if (h12_out == 7'd0) begin
            h12_out = 7'd12;
        end
        h12_byte = pack_val(h12_out, fmt_bin);
        fld_n[FLD_HOUR] = hr24 ? pack_val(nxt.hr, fmt_bin)
                               : {nxt.hr >= 7'd12, h12_byte[6:0]};
    end

    // one register per field: reset, else software write, else advance
    for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_field
        localparam logic [SEL_W-1:0]  IDX  = SEL_W'(gi);
        localparam logic [BYTE_W-1:0] INIT =
            (gi == int'(FLD_WDAY) || gi == int'(FLD_DATE) || gi == int'(FLD_MONTH))
                ? 8'h01 : 8'h00;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fld_q[gi] <= INIT;
            end else if (wr_en && wr_sel == IDX) begin
                fld_q[gi] <= wr_data;
            end else if (adv) begin
                fld_q[gi] <= fld_n[gi];
            end
        end
    end

    // records that the fall-back jump happened; cleared by a write or a new day
    always_ff @(posedge clk) begin
        if (!rst_n || wr_en) begin
            fall_done <= 1'b0;
        end else if (adv) begin
            if (day_wrap) begin
                fall_done <= 1'b0;
            end else if (fall_fire) begin
                fall_done <= 1'b1;
            end
        end
    end

    // completion pulse, in the same cycle as the new field values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_done <= 1'b0;
        end else begin
            upd_done <= adv;
        end
    end

    assign sec_o   = fld_q[FLD_SEC];
    assign min_o   = fld_q[FLD_MIN];
    assign hour_o  = fld_q[FLD_HOUR];
    assign wday_o  = fld_q[FLD_WDAY];
    assign date_o  = fld_q[FLD_DATE];
    assign month_o = fld_q[FLD_MONTH];
    assign year_o  = fld_q[FLD_YEAR];

    // R12
    upd_with_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> upd_done && (sec_o != $past(sec_o)));

    // R6
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold && !wr_en |=> !upd_done && $stable(sec_o) && $stable(min_o) &&
        $stable(hour_o) && $stable(wday_o) && $stable(date_o) &&
        $stable(month_o) && $stable(year_o));

    // R1
    min_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && (cur.sec < 7'd59) |=> $stable(min_o));

    // R1
    year_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !year_wrap |=> $stable(year_o));

    // R3
    bcd_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !fmt_bin |=> (sec_o[3:0] <= 4'd9) && (min_o[3:0] <= 4'd9));

    // R5
    hour12_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !hr24 |=> (hour_o[6:0] != 7'd0));
endmodule

// File: tb/caltime_core_bench.sv
module caltime_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, hold = 1'b0, fmt_bin = 1'b0, hr24 = 1'b1, dst_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;
    logic       upd_done;

    int total = 0, bad = 0;
    bit finished = 0;
    // bench model of the time, in plain integers, hour in 24-hour form
    int ms, mm, mh, mw, md, mmo, my;
    bit mfall, mbin, m24, mdst;

    caltime_core u_caltime_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hold(hold), .fmt_bin(fmt_bin),
        .hr24(hr24), .dst_en(dst_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
        .wday_o(wday_o), .date_o(date_o), .month_o(month_o), .year_o(year_o),
        .upd_done(upd_done)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] benc(int v, bit bin);
        return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] bhour(int h, bit is24, bit bin);
        int h12;
        if (is24) return benc(h, bin);
        h12 = h % 12;
        if (h12 == 0) h12 = 12;
        return {h >= 12, 7'(benc(h12, bin))};
    endfunction

    function automatic int bdays(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic int pick(int lo, int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        check(req, "sec", sec_o, benc(ms, mbin));
        check(req, "min", min_o, benc(mm, mbin));
        check(req, "hour", hour_o, bhour(mh, m24, mbin));
        check(req, "wday", wday_o, benc(mw, mbin));
        check(req, "date", date_o, benc(md, mbin));
        check(req, "month", month_o, benc(mmo, mbin));
        check(req, "year", year_o, benc(my, mbin));
    endtask

    task automatic model_step();
        bit sp, fa;
        sp = mdst && mmo == 4 && mw == 1 && md <= 7 && mh == 1 && mm == 59 && ms == 59;
        fa = mdst && !mfall && mmo == 10 && mw == 1 && md >= 25 && mh == 1 && mm == 59 && ms == 59;
        if (sp) begin
            mh = 3; mm = 0; ms = 0;
        end else if (fa) begin
            mm = 0; ms = 0; mfall = 1;
        end else begin
            ms++;
            if (ms == 60) begin
                ms = 0; mm++;
                if (mm == 60) begin
                    mm = 0; mh++;
                    if (mh == 24) begin
                        mh = 0; mfall = 0;
                        mw = (mw == 7) ? 1 : mw + 1;
                        md++;
                        if (md > bdays(mmo, my)) begin
                            md = 1; mmo++;
                            if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
                        end
                    end
                end
            end
        end
    endtask

    task automatic wr_field(int sel, logic [7:0] val);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R7: load the model time through the write port under hold
    task automatic load(int s, int m, int h, int w, int d, int mo, int y);
        ms = s; mm = m; mh = h; mw = w; md = d; mmo = mo; my = y;
        fmt_bin = mbin; hr24 = m24; dst_en = mdst; hold = 1'b1;
        wr_field(0, benc(ms, mbin));
        wr_field(1, benc(mm, mbin));
        wr_field(2, bhour(mh, m24, mbin));
        wr_field(3, benc(mw, mbin));
        wr_field(4, benc(md, mbin));
        wr_field(5, benc(mmo, mbin));
        wr_field(6, benc(my, mbin));
        mfall = 0; hold = 1'b0;
        @(negedge clk);
    endtask

    // R12: one accepted tick, pulse the next cycle only
    task automatic do_tick(string req);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_step();
        check("R12", "upd_done high", {7'd0, upd_done}, 8'd1);
        compare_all(req);
        @(negedge clk);
        check("R12", "upd_done drop", {7'd0, upd_done}, 8'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (2) @(negedge clk);
        // R14: reset state
        mbin = 0; m24 = 1; mdst = 0; mfall = 0;
        ms = 0; mm = 0; mh = 0; mw = 1; md = 1; mmo = 1; my = 0;
        compare_all("R14");
        check("R14", "upd_done", {7'd0, upd_done}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R8: year rollover in BCD, 24-hour
        load(59, 59, 23, 7, 31, 12, 99);
        do_tick("R1_R8");
        // R4: plain hour step in 24-hour form
        load(59, 59, 12, 3, 10, 6, 10);
        do_tick("R4");
        // R2: leap and non-leap February
        load(59, 59, 23, 2, 28, 2, 24);
        do_tick("R2");
        load(59, 59, 23, 3, 29, 2, 24);
        do_tick("R2");
        load(59, 59, 23, 4, 28, 2, 23);
        do_tick("R2");
        load(59, 59, 23, 5, 30, 4, 23);
        do_tick("R2");
        // R3: binary encoding
        mbin = 1;
        load(59, 59, 23, 6, 31, 1, 45);
        do_tick("R3");
        // R5: 12-hour steps, AM to PM, PM to AM, 12 to 1
        m24 = 0;
        load(59, 59, 11, 1, 5, 5, 5);
        do_tick("R5");
        mbin = 0;
        load(59, 59, 23, 1, 5, 5, 5);
        do_tick("R5");
        load(59, 59, 12, 1, 5, 5, 5);
        do_tick("R5");
        check("R5", "hour 1pm", hour_o, 8'h81);
        m24 = 1;

        // R6: held tick changes nothing
        load(10, 20, 5, 2, 3, 4, 5);
        hold = 1'b1; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check("R6", "upd_done", {7'd0, upd_done}, 8'd0);
        compare_all("R6");
        hold = 1'b0;
        @(negedge clk);

        // R7: write and tick in one cycle; write wins, no pulse
        tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = benc(33, mbin);
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        ms = 33; mfall = 0;
        check("R7", "upd_done", {7'd0, upd_done}, 8'd0);
        compare_all("R7");
        // R7: select code 7 changes no field
        wr_field(7, 8'h55);
        compare_all("R7");

        // R13: switching format leaves bytes alone
        mbin = 0;
        load(19, 5, 3, 2, 4, 5, 7);
        hold = 1'b1; fmt_bin = 1'b1;
        @(negedge clk);
        check("R13", "sec kept", sec_o, 8'h19);
        hold = 1'b0; mbin = 1; ms = 25;
        do_tick("R13");
        check("R13", "sec binary", sec_o, 8'h1A);

        // R9: spring forward, 24-hour BCD and 12-hour binary
        mbin = 0; mdst = 1;
        load(59, 59, 1, 1, 3, 4, 22);
        do_tick("R9");
        check("R9", "hour 3", hour_o, 8'h03);
        mbin = 1; m24 = 0;
        load(59, 59, 1, 1, 7, 4, 22);
        do_tick("R9");
        m24 = 1; mbin = 0;
        load(59, 59, 1, 1, 8, 4, 22);
        do_tick("R9");
        // R11: no jumps without dst_en
        mdst = 0;
        load(59, 59, 1, 1, 3, 4, 22);
        do_tick("R11");
        check("R11", "hour 2", hour_o, 8'h02);
        load(59, 59, 1, 1, 30, 10, 22);
        do_tick("R11");
        // R10: fall back once, then run through the repeated hour
        mdst = 1;
        load(59, 59, 1, 1, 30, 10, 22);
        do_tick("R10");
        check("R10", "hour back", hour_o, 8'h01);
        for (int i = 0; i < 3600; i++) do_tick("R10");
        check("R10", "second pass", hour_o, 8'h02);
        load(59, 59, 1, 1, 18, 10, 22);
        do_tick("R10");

        // random patterns against the bench model
        for (int it = 0; it < 400; it++) begin
            int rs, rm, rh, rd, rmo, ry;
            mbin = 1'($urandom); m24 = 1'($urandom); mdst = 1'($urandom);
            rmo = ($urandom % 4 == 0) ? pick(0, 1) * 6 + 4 : pick(1, 12);
            ry  = pick(0, 99);
            rd  = ($urandom % 2 == 0) ? bdays(rmo, ry) : pick(1, bdays(rmo, ry));
            rh  = ($urandom % 3 == 0) ? pick(0, 1) * 22 + 1 : pick(0, 23);
            rm  = ($urandom % 2 == 0) ? 59 : pick(0, 59);
            rs  = ($urandom % 3 != 0) ? 59 : pick(0, 59);
            load(rs, rm, rh, pick(1, 7), rd, rmo, ry);
            for (int k = 0; k < pick(1, 3); k++) do_tick("R1_R3_R5");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule